// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers a set of interrupt request lines and picks, at each instruction boundary, the one request that should be offered to a processor core. Every source has its own enable bit and a two-bit priority level built from two separate configuration words. A global enable gates all sources at once. When several requests are pending, the highest level wins. Within one level, a fixed polling order in which the lower source index wins breaks the tie.

The controller tracks nesting with one in-service bit per level. Acknowledging a presented vector marks that vector's level as in service. A return-from-interrupt pulse retires the highest level that is in service. A new request is offered only if its level is strictly above the highest level in service, so a routine at the top level can never be interrupted.

The offer acts as a stream handshake: `irq_valid` with `irq_idx` is the data, and `vec_ack` is the ready. Once `irq_valid` is raised, the controller holds it and the index steady across cycles without a boundary, for as long as the core applies back-pressure. The offer ends in one of two ways. An acknowledge retires it. Otherwise, the next boundary evaluates the offer again and may replace or withdraw it. If an acknowledge and a boundary arrive in the same cycle, the acknowledge takes precedence.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_valid` is low, no level is in service, and all source enables, priority bits and the global enable are zero. Requests are therefore ignored until the controller is configured.
- R2: A request is eligible only when its source enable bit is set and the global enable (bit 0 of select 3) is set.
- R3: A write with `cfg_wr` high stores `cfg_wdata` into the register chosen by `cfg_sel`. Select 0 holds the source enables, select 1 the low priority bits, select 2 the high priority bits, and select 3 the global enable. A source's level is {high bit, low bit}, so level 3 is the highest and level 0 the lowest.
- R4: Among eligible requests at a boundary, one of the highest level is chosen.
- R5: Among eligible requests that share the highest pending level, the lowest source index is chosen.
- R6: Arbitration happens only in a cycle with `insn_bound` high. The result appears on `irq_valid` and `irq_idx` one cycle later. Without a boundary or an acknowledge, the outputs hold, even when requests change.
- R7: `vec_ack` while `irq_valid` is high clears `irq_valid` on the next cycle and marks the presented level as in service.
- R8: A request is offered only if its level is strictly greater than the highest in-service level. When no level is in service, any level is offered.
- R9: While level 3 is in service, no request is offered.
- R10: `reti` clears the highest set in-service bit, and the next lower in-service level then becomes the level used in the R8 comparison.
- R11: At each boundary the offer is evaluated again. If nothing qualifies, `irq_valid` drops. If another request now wins, `irq_idx` changes to that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NUM_SRC | Level-sensitive request lines |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | NUM_SRC | Configuration write data |
| insn_bound | input | 1 | Instruction-boundary strobe |
| vec_ack | input | 1 | Vector acknowledge (ready) |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_valid | output | 1 | Request offered to core |
| irq_idx | output | $clog2(NUM_SRC) | Index of the offered source |

## Verification
The bench targets the preemption boundary, which is the case where a pending request sits at exactly the active level. A design that compared with greater-or-equal would wrongly nest a routine at its own level. The bench also takes tie-breaking within one level and between levels made only from the high bit or only from the low bit. A swapped priority bit order or a highest-index poll would show up there as the wrong `irq_idx`. Further cases are the hold of an offer while requests change between boundaries, where a design that arbitrates every cycle would change its index early, and unwinding after `reti`. A design that cleared the lowest in-service bit would then allow or block the wrong levels.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [1:0] {
    SEL_SRC_EN  = 2'd0,
    SEL_PRIO_LO = 2'd1,
    SEL_PRIO_HI = 2'd2,
    SEL_GLOBAL  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/prio_irq_cfg.sv
module prio_irq_cfg
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [1:0]         cfg_sel,
  input  logic [NUM_SRC-1:0] cfg_wdata,
  output logic [NUM_SRC-1:0] src_en,
  output logic [NUM_SRC-1:0] prio_lo,
  output logic [NUM_SRC-1:0] prio_hi,
  output logic               glb_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_en  <= '0;
      prio_lo <= '0;
      prio_hi <= '0;
      glb_en  <= 1'b0;
    end else if (cfg_wr) begin
      case (cfg_sel_e'(cfg_sel))
        SEL_SRC_EN:  src_en  <= cfg_wdata;
        SEL_PRIO_LO: prio_lo <= cfg_wdata;
        SEL_PRIO_HI: prio_hi <= cfg_wdata;
        SEL_GLOBAL:  glb_en  <= cfg_wdata[0];
        default:     glb_en  <= glb_en;
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4,
  parameter int LVL     = 0
) (
  input  logic [NUM_SRC-1:0] elig,
  input  logic [NUM_SRC-1:0] prio_lo,
  input  logic [NUM_SRC-1:0] prio_hi,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);
  logic [NUM_SRC-1:0] at_lvl;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      at_lvl[i] = elig[i] && ({prio_hi[i], prio_lo[i]} == lvl_t'(LVL));
    end
  end

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (at_lvl[i]) idx = IDX_W'(i);
    end
    hit = |at_lvl;
  end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_SRC-1:0] elig,
  input  logic [NUM_SRC-1:0] prio_lo,
  input  logic [NUM_SRC-1:0] prio_hi,
  output logic               any,
  output logic [IDX_W-1:0]   win_idx,
  output lvl_t               win_lvl
);
  logic [NUM_LVL-1:0] lvl_hit;
  logic [IDX_W-1:0]   lvl_idx [NUM_LVL];

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    prio_irq_pick #(
      .NUM_SRC(NUM_SRC),
      .IDX_W  (IDX_W),
      .LVL    (l)
    ) u_pick (
      .elig   (elig),
      .prio_lo(prio_lo),
      .prio_hi(prio_hi),
      .hit    (lvl_hit[l]),
      .idx    (lvl_idx[l])
    );
  end

  // higher level overrides: the last level with a hit wins
  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (lvl_hit[l]) begin
        any     = 1'b1;
        win_idx = lvl_idx[l];
        win_lvl = lvl_t'(l);
      end
    end
  end
endmodule

// File: rtl/prio_irq_nest.sv
module prio_irq_nest
  import prio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  lvl_t push_lvl,
  input  logic pop,
  output logic act_vld,
  output lvl_t act_lvl
);
  logic [NUM_LVL-1:0] isr_q;
  logic [NUM_LVL-1:0] top_oh;
  logic [NUM_LVL-1:0] set_oh;

  always_comb begin
    act_vld = 1'b0;
    act_lvl = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (isr_q[l]) begin
        act_vld = 1'b1;
        act_lvl = lvl_t'(l);
      end
    end
    top_oh = act_vld ? (NUM_LVL'(1) << act_lvl) : '0;
    set_oh = push ? (NUM_LVL'(1) << push_lvl) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= (isr_q & ~(pop ? top_oh : '0)) | set_oh;
  end

  // R7
  push_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> isr_q[$past(push_lvl)]);

  // R10
  pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && (isr_q != '0)) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               cfg_wr,
  input  logic [1:0]         cfg_sel,
  input  logic [NUM_SRC-1:0] cfg_wdata,
  input  logic               insn_bound,
  input  logic               vec_ack,
  input  logic               reti,
  output logic               irq_valid,
  output logic [IDX_W-1:0]   irq_idx
);
  logic [NUM_SRC-1:0] src_en, prio_lo, prio_hi, elig;
  logic               glb_en;
  logic               arb_any, cand_ok, take;
  logic [IDX_W-1:0]   arb_idx;
  lvl_t               arb_lvl, lvl_q, act_lvl;
  logic               act_vld, vld_q;
  logic [IDX_W-1:0]   idx_q;

  prio_irq_cfg #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .src_en   (src_en),
    .prio_lo  (prio_lo),
    .prio_hi  (prio_hi),
    .glb_en   (glb_en)
  );

  assign elig = src_req & src_en & {NUM_SRC{glb_en}};

  prio_irq_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .elig   (elig),
    .prio_lo(prio_lo),
    .prio_hi(prio_hi),
    .any    (arb_any),
    .win_idx(arb_idx),
    .win_lvl(arb_lvl)
  );

  assign take    = vec_ack && vld_q;
  assign cand_ok = arb_any && (!act_vld || (arb_lvl > act_lvl));

  prio_irq_nest u_nest (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (take),
    .push_lvl(lvl_q),
    .pop     (reti),
    .act_vld (act_vld),
    .act_lvl (act_lvl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      idx_q <= '0;
      lvl_q <= '0;
    end else if (take) begin
      vld_q <= 1'b0;
    end else if (insn_bound) begin
      vld_q <= cand_ok;
      idx_q <= arb_idx;
      lvl_q <= arb_lvl;
    end
  end

  assign irq_valid = vld_q;
  assign irq_idx   = idx_q;

  // R6
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !insn_bound && !vec_ack) |=> (vld_q && $stable(idx_q)));

  // R2
  glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> $past(glb_en));

  // R8
  strict_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> (!$past(act_vld) || (lvl_q > $past(act_lvl))));

  // R9
  top_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_vld && (act_lvl == lvl_t'(NUM_LVL - 1)) && insn_bound && !vec_ack) |=> !vld_q);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int NS = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_req = '0;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [NS-1:0] cfg_wdata = '0;
  logic          insn_bound = 1'b0;
  logic          vec_ack = 1'b0;
  logic          reti = 1'b0;
  logic          irq_valid;
  logic [3:0]    irq_idx;

  always #10 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .insn_bound(insn_bound),
    .vec_ack(vec_ack), .reti(reti), .irq_valid(irq_valid), .irq_idx(irq_idx)
  );

  int total = 0;
  int bad = 0;

  typedef struct { bit v; int idx; string tag; } exp_t;
  exp_t exp_q[$];

  // reference state kept from the requirements
  bit [NS-1:0] en_m = '0, plo_m = '0, phi_m = '0;
  bit          gen_m = 1'b0;
  bit [3:0]    isr_m = '0;
  bit          exp_v;
  int          exp_lvl;

  task automatic check(bit ok, string tag, int gv, int gi, int ev, int ei);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got valid=%0d idx=%0d, want valid=%0d idx=%0d", tag, gv, gi, ev, ei);
    end
  endtask

  function automatic void model(output bit v, output int idx, output int lvl);
    int act;
    act = -1;
    v = 0; idx = 0; lvl = 0;
    for (int l = 0; l < 4; l++) if (isr_m[l]) act = l;
    for (int l = 3; l >= 0; l--)
      for (int i = 0; i < NS; i++)
        if (!v && gen_m && en_m[i] && src_req[i] && (int'({phi_m[i], plo_m[i]}) == l)) begin
          v = 1; idx = i; lvl = l;
        end
    if (v && lvl <= act) v = 0;
  endfunction

  task automatic cfg_write(int sel, bit [NS-1:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_sel = 2'(sel); cfg_wdata = d;
    case (sel)
      0: en_m = d;
      1: plo_m = d;
      2: phi_m = d;
      default: gen_m = d[0];
    endcase
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic boundary(bit [NS-1:0] req, string tag);
    bit v; int i; int l;
    @(negedge clk);
    src_req = req;
    insn_bound = 1;
    model(v, i, l);
    exp_v = v; exp_lvl = l;
    @(negedge clk);
    insn_bound = 0;
    #1 exp_q.push_back('{v, i, tag});
  endtask

  task automatic ack(string tag);
    @(negedge clk);
    vec_ack = 1;
    if (exp_v) isr_m[exp_lvl] = 1;
    @(negedge clk);
    vec_ack = 0;
    #1 check(irq_valid === 1'b0, tag, int'(irq_valid), int'(irq_idx), 0, 0);
    exp_v = 0;
  endtask

  task automatic do_reti();
    @(negedge clk);
    reti = 1;
    for (int l = 3; l >= 0; l--)
      if (isr_m[l]) begin isr_m[l] = 0; break; end
    @(negedge clk);
    reti = 0;
  endtask

  // monitor: pop expectations and compare against the outputs
  initial begin
    forever begin
      exp_t it;
      wait (exp_q.size() > 0);
      it = exp_q.pop_front();
      if (it.v)
        check(irq_valid === 1'b1 && int'(irq_idx) == it.idx, it.tag,
              int'(irq_valid), int'(irq_idx), 1, it.idx);
      else
        check(irq_valid === 1'b0, it.tag, int'(irq_valid), int'(irq_idx), 0, 0);
    end
  end

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog", 0, 0, 1, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 check(irq_valid === 1'b0, "R1 reset", int'(irq_valid), int'(irq_idx), 0, 0);
    boundary(16'hFFFF, "R1 unconfigured");

    cfg_write(0, 16'hFFFF);
    boundary(16'hFFFF, "R2 global off");
    cfg_write(3, 16'h0001);
    boundary(16'hFFFF, "R5 lowest index");
    boundary(16'h0A00, "R5 tie level0");

    // src12 -> level1, src4 -> level2, src7 -> level3
    cfg_write(1, 16'h1080);
    cfg_write(2, 16'h0090);
    boundary(16'h1008, "R4 higher level");
    boundary(16'h1018, "R3 high bit outranks low bit");

    // hold without boundary
    @(negedge clk); src_req = 16'h0008;
    repeat (3) @(negedge clk);
    #1 check(irq_valid === 1'b1 && irq_idx == 4'd4, "R6 hold", int'(irq_valid), int'(irq_idx), 1, 4);
    boundary(16'h0008, "R11 replaced");
    boundary(16'h0000, "R11 withdrawn");

    cfg_write(0, 16'hFFEF);
    boundary(16'h0018, "R2 source disabled");
    cfg_write(0, 16'hFFFF);

    boundary(16'h0008, "R8 idle takes level0");
    ack("R7 ack clears");
    boundary(16'h0028, "R8 equal level blocked");
    boundary(16'h1000, "R8 higher preempts");
    ack("R7 ack level1");
    boundary(16'h1008, "R8 not above active");
    boundary(16'h0080, "R8 level3 preempts");
    ack("R7 ack level3");
    boundary(16'hFFFF, "R9 top blocks all");

    do_reti();
    boundary(16'h0010, "R10 level2 above level1");
    boundary(16'h1000, "R10 level1 equal active");
    do_reti();
    boundary(16'h1000, "R10 level1 above level0");
    ack("R7 ack again");
    do_reti();
    do_reti();
    boundary(16'h0008, "R10 empty stack");

    #5;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule